// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block is a row of boundary-scan cells that sits between a chip's core logic and its pins. Each cell owns one signal crossing that boundary. It has a capture/shift flop and an update latch behind it. A parallel output mux then decides whether the far side sees the near side directly or sees the latched test value. The cells are strung into one serial path. Test data enters at the first cell from the serial input and leaves from the last cell toward the serial output.

The strobes come from an external test-access controller: capture, shift, update and a test-mode select. Capture and shift act on the rising edge of the test clock. Update acts on the falling edge. Capture has priority over shift when both are raised together. In normal mode every parallel output simply follows its parallel input, so the chip works as usual. Even then, data can still be captured and shifted and a vector preloaded into the update latches. In test mode each parallel output is driven from its update latch, which cuts it off from the other side.

A generic cell serves both directions. On an output pin its parallel input is the core signal. On an input pin its parallel input is the pad. Capture therefore observes whichever side feeds the cell.

Top module: `bscan_chain`

## Requirements
- R1: While `rst_n` is low, all capture/shift flops and all update latches are cleared to 0 asynchronously, so `serial_out` is 0 and, with `test_mode`=1, `par_out` is all zeros.
- R2: With `test_mode`=0, `par_out[i]` equals `par_in[i]` for every cell at all times, whatever the strobes are doing.
- R3: With `test_mode`=1, `par_out[i]` equals the update latch of cell i.
- R4: On a rising `tck` edge with `capture_en`=1, every cell's flop loads its `par_in` bit; this holds even when `shift_en` is also 1 (capture wins).
- R5: On a rising `tck` edge with `shift_en`=1 and `capture_en`=0, cell 0 loads `serial_in` and cell i loads cell i-1. `serial_out` is the flop of cell N-1, so after N shifts the first bit entered appears on `serial_out`; a vector fed most-significant bit first ends with bit i in cell i.
- R6: On a falling `tck` edge with `update_en`=1 each update latch loads its cell's flop; at any other time the latches hold, including through shifting and capture.
- R7: On a rising edge with both `capture_en` and `shift_en` at 0, the flops keep their contents regardless of `serial_in` and `par_in`.
- R8: A vector can be shifted in and updated while `test_mode`=0 without changing `par_out`, and it appears on `par_out` as soon as `test_mode` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; capture/shift on rise, update on fall |
| rst_n | input | 1 | Asynchronous active-low test-logic reset |
| capture_en | input | 1 | Load the flops from the parallel inputs |
| shift_en | input | 1 | Shift the flops one place toward `serial_out` |
| update_en | input | 1 | Copy the flops into the update latches on the falling edge |
| test_mode | input | 1 | 1: parallel outputs from update latches; 0: pass-through |
| serial_in | input | 1 | Serial data entering cell 0 |
| serial_out | output | 1 | Serial data leaving cell N-1 |
| par_in | input | N | Parallel data arriving at each cell (core or pad side) |
| par_out | output | N | Parallel data leaving each cell (pad or core side) |

## Verification
A table of vectors is shifted in one after another: all zeros, all ones, alternating bits, and single ones at each end. Each shift also pushes out the previous vector, so bit order and chain length are checked from both directions. A wrong order, a skipped cell, or an off-by-one in the chain shows up as a mismatch on one of the end patterns. During the shifting, pass-through is held with a parallel input that differs from the shifted data, which separates a true bypass from leakage of the latch or flop. Directed runs then show whether capture beats shift, whether the flops hold with no strobes, whether the latches stay put through capture and shift in test mode, and whether an asynchronous reset clears both storage ranks.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_SHIFT   = 2'd1,
    OP_CAPTURE = 2'd2
  } stage_op_e;

  // Capture outranks shift when both strobes are raised.
  function automatic stage_op_e pick_op(input logic cap, input logic sh);
    if (cap)     return OP_CAPTURE;
    else if (sh) return OP_SHIFT;
    else         return OP_HOLD;
  endfunction

  function automatic logic next_stage(input stage_op_e op, input logic ser,
                                      input logic par, input logic cur);
    case (op)
      OP_CAPTURE: return par;
      OP_SHIFT:   return ser;
      default:    return cur;
    endcase
  endfunction

  function automatic logic drive_sel(input logic tst, input logic thru,
                                     input logic held);
    return tst ? held : thru;
  endfunction

endpackage

// File: rtl/bsc_capture_stage.sv
module bsc_capture_stage
  import bsc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  stage_op_e op,
  input  logic      ser_in,
  input  logic      par_in,
  output logic      q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= next_stage(op, ser_in, par_in, q);
  end
endmodule

// File: rtl/bsc_update_latch.sv
module bsc_update_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic d,
  output logic q
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/bsc_out_mux.sv
module bsc_out_mux
  import bsc_pkg::*;
(
  input  logic test_mode,
  input  logic thru,
  input  logic held,
  output logic y
);
  always_comb y = drive_sel(test_mode, thru, held);
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bsc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         capture_en,
  input  logic         shift_en,
  input  logic         update_en,
  input  logic         test_mode,
  input  logic         serial_in,
  output logic         serial_out,
  input  logic [N-1:0] par_in,
  output logic [N-1:0] par_out
);
  localparam int LAST = N - 1;

  // Named events for the checker.
  stage_op_e   stage_op;
  logic        cap_fire;
  logic        shift_fire;
  logic        upd_fire;
  logic [N-1:0] ser_feed;
  logic [N-1:0] stage_vec;
  logic [N-1:0] upd_vec;

  always_comb begin
    stage_op   = pick_op(capture_en, shift_en);
    cap_fire   = (stage_op == OP_CAPTURE);
    shift_fire = (stage_op == OP_SHIFT);
    upd_fire   = update_en;
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_cell
      if (i == 0) begin : g_head
        assign ser_feed[i] = serial_in;
      end else begin : g_body
        assign ser_feed[i] = stage_vec[i-1];
      end

      bsc_capture_stage u_stage (
        .clk    (tck),
        .rst_n  (rst_n),
        .op     (stage_op),
        .ser_in (ser_feed[i]),
        .par_in (par_in[i]),
        .q      (stage_vec[i])
      );

      bsc_update_latch u_latch (
        .clk   (tck),
        .rst_n (rst_n),
        .load  (upd_fire),
        .d     (stage_vec[i]),
        .q     (upd_vec[i])
      );

      bsc_out_mux u_mux (
        .test_mode (test_mode),
        .thru      (par_in[i]),
        .held      (upd_vec[i]),
        .y         (par_out[i])
      );
    end
  endgenerate

  assign serial_out = stage_vec[LAST];

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int N = 8
) (
  input logic         tck,
  input logic         rst_n,
  input logic         capture_en,
  input logic         shift_en,
  input logic         update_en,
  input logic         test_mode,
  input logic         serial_in,
  input logic         serial_out,
  input logic [N-1:0] par_in,
  input logic [N-1:0] par_out,
  input logic [N-1:0] stage_vec,
  input logic [N-1:0] upd_vec
);
  AST_RESET_CLEAR: assert property (@(posedge tck)
    !rst_n |-> (stage_vec == '0 && upd_vec == '0)); // R1

  AST_PASS_THRU: assert property (@(posedge tck) disable iff (!rst_n)
    !test_mode |-> par_out == par_in); // R2

  AST_TEST_DRIVE: assert property (@(posedge tck) disable iff (!rst_n)
    test_mode |-> par_out == upd_vec); // R3

  AST_CAPTURE_LOAD: assert property (@(posedge tck) disable iff (!rst_n)
    capture_en |=> stage_vec == $past(par_in)); // R4

  AST_SHIFT_HEAD: assert property (@(posedge tck) disable iff (!rst_n)
    (shift_en && !capture_en) |=> stage_vec[0] == $past(serial_in)); // R5

  AST_SHIFT_BODY: assert property (@(posedge tck) disable iff (!rst_n)
    (shift_en && !capture_en) |=> stage_vec[N-1:1] == $past(stage_vec[N-2:0])); // R5

  AST_SERIAL_TAIL: assert property (@(posedge tck) disable iff (!rst_n)
    serial_out == stage_vec[N-1]); // R5

  AST_UPDATE_LOAD: assert property (@(negedge tck) disable iff (!rst_n)
    update_en |=> upd_vec == $past(stage_vec)); // R6

  AST_UPDATE_HOLD: assert property (@(negedge tck) disable iff (!rst_n)
    !update_en |=> $stable(upd_vec)); // R6

  AST_STAGE_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
    (!capture_en && !shift_en) |=> $stable(stage_vec)); // R7
endmodule

bind bscan_chain bscan_chain_chk #(.N(N)) u_chk (
  .tck        (tck),
  .rst_n      (rst_n),
  .capture_en (capture_en),
  .shift_en   (shift_en),
  .update_en  (update_en),
  .test_mode  (test_mode),
  .serial_in  (serial_in),
  .serial_out (serial_out),
  .par_in     (par_in),
  .par_out    (par_out),
  .stage_vec  (stage_vec),
  .upd_vec    (upd_vec)
);

// File: tb/bscan_chain_tb.sv
module bscan_chain_tb;
  localparam int N = 8;
  localparam int NV = 6;
  // Each entry: {vector to shift in, parallel input held meanwhile}
  localparam logic [2*N-1:0] TABLE [NV] = '{
    {8'h00, 8'hFF}, {8'hFF, 8'h00}, {8'hA5, 8'h5A},
    {8'h5A, 8'hA5}, {8'h01, 8'hFE}, {8'h80, 8'h7F}
  };

  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0;
  logic test_mode = 1'b0, serial_in = 1'b0;
  logic serial_out;
  logic [N-1:0] par_in = '0;
  logic [N-1:0] par_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 tck = ~tck; // 50 MHz

  bscan_chain #(.N(N)) u_dut (
    .tck(tck), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .test_mode(test_mode), .serial_in(serial_in),
    .serial_out(serial_out), .par_in(par_in), .par_out(par_out)
  );

  task automatic check(input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive strobes just after a rising edge; an update acts on the coming
  // falling edge, capture/shift on the next rising edge. Strobes drop after.
  task automatic drive(input logic c, input logic s, input logic u,
                       input logic si);
    capture_en = c; shift_en = s; update_en = u; serial_in = si;
    @(posedge tck); #5;
    capture_en = 0; shift_en = 0; update_en = 0;
  endtask

  task automatic shift_out_check(input logic [N-1:0] exp, input string req);
    for (int k = 0; k < N; k++) begin
      check(req, {{(N-1){1'b0}}, serial_out}, {{(N-1){1'b0}}, exp[N-1-k]});
      drive(0, 1, 0, 1'b0);
    end
  endtask

  always @(posedge tck) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] prev;
    logic [N-1:0] held;
    repeat (3) @(posedge tck);
    #5;
    test_mode = 1;
    #1;
    check("R1 reset par_out", par_out, '0);
    check("R1 reset serial_out", {{(N-1){1'b0}}, serial_out}, '0);
    rst_n = 1;
    drive(0, 0, 0, 0);
    prev = '0;

    // Table: shift each vector in while pins pass through, then apply it.
    for (int e = 0; e < NV; e++) begin
      logic [N-1:0] vec;
      vec = TABLE[e][2*N-1:N];
      test_mode = 0;
      par_in = TABLE[e][N-1:0];
      for (int k = 0; k < N; k++) begin
        check("R5 previous vector out", {{(N-1){1'b0}}, serial_out},
              {{(N-1){1'b0}}, prev[N-1-k]});
        drive(0, 1, 0, vec[N-1-k]);
        check("R2 pass-through while shifting", par_out, par_in);
      end
      drive(0, 0, 1, 0);
      check("R8 pins untouched by update in normal mode", par_out, par_in);
      test_mode = 1;
      #1;
      check("R3 R8 preloaded vector on pins", par_out, vec);
      prev = vec;
    end

    // R6: latches hold through shift and capture in test mode.
    held = prev;
    for (int k = 0; k < N; k++) begin
      drive(0, 1, 0, ~held[N-1-k]);
      check("R6 latch holds while shifting", par_out, held);
    end
    par_in = 8'h3C;
    drive(1, 0, 0, 0);
    check("R6 latch holds through capture", par_out, held);
    // R4: captured value shifts out.
    shift_out_check(8'h3C, "R4 captured data");

    // R4: capture outranks shift.
    par_in = 8'h96;
    drive(1, 1, 0, 1'b1);
    shift_out_check(8'h96, "R4 capture priority");

    // R7: no strobe, flops hold.
    par_in = 8'hC3;
    drive(1, 0, 0, 0);
    par_in = 8'h00;
    drive(0, 0, 0, 1'b1);
    drive(0, 0, 0, 1'b0);
    drive(0, 0, 0, 1'b1);
    shift_out_check(8'hC3, "R7 idle hold");

    // R6: update loads the flops, then R1 asynchronous reset mid-run.
    par_in = 8'hFF;
    drive(1, 0, 0, 0);
    drive(0, 0, 1, 0);
    check("R6 update loads flops", par_out, 8'hFF);
    #2;
    rst_n = 0;
    #1;
    check("R1 async reset clears latches", par_out, '0);
    check("R1 async reset clears flops", {{(N-1){1'b0}}, serial_out}, '0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule